// File: doc/BRIEF.md
# Address-Sequence Command Unlock Detector

This block sits beside a memory's access port and watches the addresses of the reads that go past. Six reads in a fixed order act as a hidden command. Five key addresses are always the same. The sixth address then picks either a nonvolatile save (store) or a nonvolatile restore (recall). When the block recognises a complete sequence, it raises a one-cycle request pulse for the matching operation. It never touches the memory array. It only classifies accesses and keeps track of how far into the sequence the stream has got.

Any access that does not continue the sequence abandons it without any sign. This covers a read of the wrong address, a write, or a read made while the write-enable level is active. A read of the first key address during such an abort is taken as the opening step of a new attempt. A busy/inhibit flag, raised while the array is occupied, makes the block ignore all traffic and forget any partial sequence.

Top module: `seq_unlock_det`

## Requirements
- R1: After reset, `store_req` and `recall_req` are low and the detector is idle, at step 0.
- R2: Six qualifying reads at 0x4E38, 0xB1C7, 0x83E0, 0x7C1F, 0x703F and then 0x8FC0 make `store_req` high for exactly the clock cycle after the sixth read.
- R3: The same five-read prefix followed by a read at 0x4C63 makes `recall_req` high for exactly the cycle after the sixth read.
- R4: After the prefix, a sixth read at any address other than 0x8FC0 or 0x4C63 issues no request and ends the attempt.
- R5: A qualifying read whose address does not match the expected step aborts the sequence. If that address is 0x4E38, it becomes step one of a new sequence; otherwise the detector returns to step 0.
- R6: A cycle with `wr_stb` high aborts the sequence and returns the detector to step 0, whatever the address. This holds even at 0x4E38.
- R7: A read strobe while `wr_en` is high does not count as a step and aborts the sequence, back to step 0.
- R8: A read is a step when `ce_rd` or `oe_rd` is high. If both are high in one cycle, that cycle counts as a single step.
- R9: While `inhibit` is high, every access is ignored, the sequence is cleared to step 0 and no request is issued.
- R10: Each request is a single-cycle pulse, and `store_req` and `recall_req` are never high together.
- R11: Cycles with no read and no write strobe leave the sequence position unchanged, so idle gaps between steps are allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_addr | input | 16 | Address of the current access |
| ce_rd | input | 1 | Read strobe qualified by chip enable |
| oe_rd | input | 1 | Read strobe qualified by output enable |
| wr_en | input | 1 | Write-enable level; a read made while it is high does not count |
| wr_stb | input | 1 | Write strobe |
| inhibit | input | 1 | Busy/inhibit flag |
| store_req | output | 1 | One-cycle store request |
| recall_req | output | 1 | One-cycle recall request |

## Verification
The bound checker checks the following on every cycle:
- the two pulses never overlap and each lasts one cycle;
- each pulse traces back to a read of its command address made at the last step;
- an inhibit cycle or a write cycle always leaves the detector at step 0 with no request;
- the step position only moves forward by one, restarts at one or zero, or holds across idle cycles.

Only the bench scenarios can show which whole sequences succeed, because each outcome depends on a history of six or more accesses. Those scenarios cover:
- a wrong sixth address;
- a restart on 0x4E38;
- an abort by write, by a read with write enable high, or by inhibit;
- both read strobes in one cycle.

// File: rtl/seq_unlock_pkg.sv
package seq_unlock_pkg;
  localparam int KEY_W      = 16;
  localparam int SEQ_LEN    = 6;
  localparam int PREFIX_LEN = SEQ_LEN - 1;
  localparam int STEP_W     = $clog2(SEQ_LEN);

  localparam logic [KEY_W-1:0] STORE_KEY  = 16'h8FC0;
  localparam logic [KEY_W-1:0] RECALL_KEY = 16'h4C63;

  typedef enum logic [1:0] {ACC_NONE, ACC_READ, ACC_BREAK} acc_kind_e;
  typedef enum logic [1:0] {CMD_NONE, CMD_STORE, CMD_RECALL} cmd_e;

  // Key expected at prefix position idx (0 .. PREFIX_LEN-1)
  function automatic logic [KEY_W-1:0] prefix_key(input logic [STEP_W-1:0] idx);
    case (idx)
      3'd0:    prefix_key = 16'h4E38;
      3'd1:    prefix_key = 16'hB1C7;
      3'd2:    prefix_key = 16'h83E0;
      3'd3:    prefix_key = 16'h7C1F;
      3'd4:    prefix_key = 16'h703F;
      default: prefix_key = '0;
    endcase
  endfunction

  function automatic cmd_e decode_final(input logic [KEY_W-1:0] addr);
    if (addr == STORE_KEY)       decode_final = CMD_STORE;
    else if (addr == RECALL_KEY) decode_final = CMD_RECALL;
    else                         decode_final = CMD_NONE;
  endfunction

  // Step taken after an aborting read: the opening key restarts at one
  function automatic logic [STEP_W-1:0] restart_step(input logic [KEY_W-1:0] addr);
    restart_step = (addr == prefix_key('0)) ? STEP_W'(1) : '0;
  endfunction
endpackage

// File: rtl/sud_access_class.sv
module sud_access_class
  import seq_unlock_pkg::*;
(
  input  logic      ce_rd,
  input  logic      oe_rd,
  input  logic      wr_en,
  input  logic      wr_stb,
  input  logic      inhibit,
  output acc_kind_e kind
);
  logic any_rd;
  assign any_rd = ce_rd | oe_rd;

  always_comb begin
    if (inhibit)                 kind = ACC_BREAK;
    else if (wr_stb)             kind = ACC_BREAK;
    else if (any_rd && wr_en)    kind = ACC_BREAK;
    else if (any_rd)             kind = ACC_READ;
    else                         kind = ACC_NONE;
  end
endmodule

// File: rtl/sud_step_tracker.sv
module sud_step_tracker
  import seq_unlock_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_kind_e         kind,
  input  logic [KEY_W-1:0]  addr,
  output logic [STEP_W-1:0] step_q,
  output cmd_e              cmd_hit
);
  logic [STEP_W-1:0] step_d;
  logic              at_final;

  assign at_final = (step_q == STEP_W'(PREFIX_LEN));

  always_comb begin
    step_d  = step_q;
    cmd_hit = CMD_NONE;
    case (kind)
      ACC_BREAK: step_d = '0;
      ACC_READ: begin
        if (at_final) begin
          cmd_hit = decode_final(addr);
          step_d  = (cmd_hit == CMD_NONE) ? restart_step(addr) : '0;
        end else if (addr == prefix_key(step_q)) begin
          step_d = step_q + STEP_W'(1);
        end else begin
          step_d = restart_step(addr);
        end
      end
      default: step_d = step_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end
endmodule

// File: rtl/sud_cmd_pulse.sv
module sud_cmd_pulse
  import seq_unlock_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_e cmd_hit,
  output logic store_req,
  output logic recall_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_req  <= 1'b0;
      recall_req <= 1'b0;
    end else begin
      store_req  <= (cmd_hit == CMD_STORE);
      recall_req <= (cmd_hit == CMD_RECALL);
    end
  end
endmodule

// File: rtl/seq_unlock_det.sv
module seq_unlock_det
  import seq_unlock_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] acc_addr,
  input  logic             ce_rd,
  input  logic             oe_rd,
  input  logic             wr_en,
  input  logic             wr_stb,
  input  logic             inhibit,
  output logic             store_req,
  output logic             recall_req
);
  acc_kind_e         kind;
  cmd_e              cmd_hit;
  logic [STEP_W-1:0] step_q;
  logic              ev_read;
  logic              ev_break;

  assign ev_read  = (kind == ACC_READ);
  assign ev_break = (kind == ACC_BREAK);

  sud_access_class u_class (
    .ce_rd(ce_rd), .oe_rd(oe_rd), .wr_en(wr_en), .wr_stb(wr_stb),
    .inhibit(inhibit), .kind(kind)
  );

  sud_step_tracker u_track (
    .clk(clk), .rst_n(rst_n), .kind(kind), .addr(acc_addr),
    .step_q(step_q), .cmd_hit(cmd_hit)
  );

  sud_cmd_pulse u_pulse (
    .clk(clk), .rst_n(rst_n), .cmd_hit(cmd_hit),
    .store_req(store_req), .recall_req(recall_req)
  );
endmodule

// File: rtl/sud_checker.sv
module sud_checker
  import seq_unlock_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [KEY_W-1:0]  acc_addr,
  input logic              inhibit,
  input logic              wr_stb,
  input logic              ev_read,
  input logic              ev_break,
  input logic [STEP_W-1:0] step_q,
  input logic              store_req,
  input logic              recall_req
);
  assert_single_cmd_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_req, recall_req}));

  assert_pulse_width_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (store_req || recall_req) |=> !(store_req || recall_req));

  assert_inhibit_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (step_q == '0 && !store_req && !recall_req));

  assert_write_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !inhibit) |=> (step_q == '0 && !store_req && !recall_req));

  assert_store_origin_R2: assert property (@(posedge clk) disable iff (!rst_n)
    store_req |-> $past(ev_read && step_q == STEP_W'(PREFIX_LEN) && acc_addr == STORE_KEY));

  assert_recall_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
    recall_req |-> $past(ev_read && step_q == STEP_W'(PREFIX_LEN) && acc_addr == RECALL_KEY));

  assert_step_move_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q != $past(step_q)) |-> (step_q == STEP_W'($past(step_q) + 1'b1) || step_q <= STEP_W'(1)));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_read && !ev_break) |=> $stable(step_q));
endmodule

bind seq_unlock_det sud_checker u_chk (
  .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .inhibit(inhibit),
  .wr_stb(wr_stb), .ev_read(ev_read), .ev_break(ev_break),
  .step_q(step_q), .store_req(store_req), .recall_req(recall_req)
);

// File: tb/seq_unlock_det_bench.sv
`timescale 1ns/1ps
module seq_unlock_det_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic        ce = 1'b0, oe = 1'b0, we = 1'b0, wst = 1'b0, inh = 1'b0;
  logic        store_req, recall_req;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  int n_store = 0, n_recall = 0;

  always #2 clk = ~clk;

  seq_unlock_det u_seq_unlock_det (
    .clk(clk), .rst_n(rst_n), .acc_addr(addr), .ce_rd(ce), .oe_rd(oe),
    .wr_en(we), .wr_stb(wst), .inhibit(inh),
    .store_req(store_req), .recall_req(recall_req)
  );

  function automatic logic [15:0] bkey(input int i);
    logic [15:0] k [0:4];
    k[0] = 16'h4E38; k[1] = 16'hB1C7; k[2] = 16'h83E0; k[3] = 16'h7C1F; k[4] = 16'h703F;
    return k[i];
  endfunction

  // Independent reference model of the command recogniser
  int m_step = 0;
  bit m_store = 0, m_recall = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_store = 0; m_recall = 0;
    end else begin
      m_store = 0; m_recall = 0;
      if (inh || wst || ((ce || oe) && we)) m_step = 0;
      else if (ce || oe) begin
        if (m_step == 5) begin
          if (addr == 16'h8FC0)      begin m_store = 1;  m_step = 0; end
          else if (addr == 16'h4C63) begin m_recall = 1; m_step = 0; end
          else m_step = (addr == bkey(0)) ? 1 : 0;
        end else if (addr == bkey(m_step)) m_step = m_step + 1;
        else m_step = (addr == bkey(0)) ? 1 : 0;
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Continuous comparison against the model on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    check("R2 store_req vs model", store_req, m_store);
    check("R3 recall_req vs model", recall_req, m_recall);
    if (store_req) n_store++;
    if (recall_req) n_recall++;
  end

  task automatic acc(input logic [15:0] a, input logic c, input logic o,
                     input logic w, input logic ws, input logic ih);
    @(negedge clk);
    addr = a; ce = c; oe = o; we = w; wst = ws; inh = ih;
    @(negedge clk);
    ce = 0; oe = 0; we = 0; wst = 0; inh = 0;
    #0.5;
  endtask

  task automatic rd(input logic [15:0] a);
    acc(a, 1, 0, 0, 0, 0);
  endtask

  task automatic prefix(input int from, input int upto);
    for (int i = from; i < upto; i++) rd(bkey(i));
  endtask

  task automatic expect_out(input string tag, input logic s, input logic r);
    check({tag, " store"}, store_req, s);
    check({tag, " recall"}, recall_req, r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset store", store_req, 1'b0);
    check("R1 reset recall", recall_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    expect_out("R1 idle after reset", 0, 0);

    prefix(0, 5); rd(16'h8FC0);
    expect_out("R2 store sequence", 1, 0);
    @(negedge clk); #0.5;
    expect_out("R10 pulse ends", 0, 0);

    for (int i = 0; i < 5; i++) acc(bkey(i), 0, 1, 0, 0, 0);
    acc(16'h4C63, 0, 1, 0, 0, 0);
    expect_out("R3 recall via oe reads R8", 0, 1);

    for (int i = 0; i < 5; i++) acc(bkey(i), 1, 1, 0, 0, 0);
    acc(16'h4C63, 1, 1, 0, 0, 0);
    expect_out("R8 both strobes one step", 0, 1);

    prefix(0, 5); rd(16'h1234);
    expect_out("R4 wrong sixth", 0, 0);
    prefix(0, 5); rd(16'h8FC0);
    expect_out("R4 fresh after wrong sixth", 1, 0);

    prefix(0, 5); rd(16'h4E38);
    expect_out("R5 sixth is key0", 0, 0);
    prefix(1, 5); rd(16'h8FC0);
    expect_out("R5 restart counted", 1, 0);

    prefix(0, 3); rd(16'hAAAA); prefix(3, 5); rd(16'h8FC0);
    expect_out("R5 mid abort", 0, 0);

    prefix(0, 2); acc(bkey(2), 0, 0, 0, 1, 0); prefix(2, 5); rd(16'h8FC0);
    expect_out("R6 write aborts", 0, 0);
    prefix(0, 3); acc(16'h4E38, 0, 0, 0, 1, 0); prefix(1, 5); rd(16'h4C63);
    expect_out("R6 write at key0 no restart", 0, 0);

    prefix(0, 4); acc(bkey(4), 1, 0, 1, 0, 0); rd(16'h8FC0);
    expect_out("R7 read with we", 0, 0);

    prefix(0, 3); acc(bkey(3), 1, 0, 0, 0, 1); prefix(3, 5); rd(16'h8FC0);
    expect_out("R9 inhibit clears", 0, 0);
    prefix(0, 5); acc(16'h8FC0, 1, 0, 0, 0, 1);
    expect_out("R9 inhibit on sixth", 0, 0);

    for (int i = 0; i < 5; i++) begin rd(bkey(i)); repeat (3) @(negedge clk); end
    rd(16'h4C63);
    expect_out("R11 idle gaps hold", 0, 1);

    // Constrained random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      int r;
      @(negedge clk);
      ce = 0; oe = 0; we = 0; wst = 0; inh = 0;
      r = int'($urandom % 100);
      if (r < 8) begin
        addr = 16'($urandom);
      end else if (r < 12) begin
        addr = bkey(int'($urandom % 5)); wst = 1;
      end else if (r < 15) begin
        addr = bkey(int'($urandom % 5)); ce = 1; we = 1;
      end else if (r < 18) begin
        addr = bkey(int'($urandom % 5)); ce = 1; inh = 1;
      end else begin
        int p = int'($urandom % 100);
        int s = int'($urandom % 3);
        ce = (s != 1); oe = (s != 0);
        if (p < 80) begin
          if (m_step == 5) addr = ($urandom % 2) ? 16'h8FC0 : 16'h4C63;
          else addr = bkey(m_step);
        end else if (p < 90) addr = bkey(0);
        else addr = 16'($urandom);
      end
    end
    @(negedge clk);
    ce = 0; oe = 0; we = 0; wst = 0; inh = 0;
    repeat (3) @(negedge clk);
    tests++;
    if (n_store == 0 || n_recall == 0) begin
      fails++;
      $display("FAIL R2/R3 coverage: stores=%0d recalls=%0d expected >0", n_store, n_recall);
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule